// File: doc/BRIEF.md
# Multi-Domain Reset Sequencing Controller

This block sequences the resets of a small networking device whose logic is split into several reset domains: the host bus interface, the host-side MAC, the lower system register bank and a configurable number of PHY ports. A host write with the soft bit set runs a whole-device soft sequence. The three host-side domains are held in reset for a fixed number of cycles. An external configuration loader is then started in a restricted pass that fetches only the MAC address. After the loader reports completion, the block waits a settle interval whose length depends on the loader's memory bus type. The PHY domains keep running throughout, and the configuration straps, captured once after power-on, are left untouched.

Each PHY has its own reset request bit. A request gives a timed reset pulse to that PHY alone, and its status bit clears by itself when the pulse ends, so the host can poll for completion. Leaving a PHY power-down state raises the same pulse together with a "keep registers" qualifier, which tells the PHY to skip reinitialising its configuration registers. PHY requests that arrive while a sequence is running are held and serviced once the sequence ends. A loader that never answers is cut off by a timeout, and a sticky error flag is then raised. Every interval is a parameter counted in clock cycles.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A write with `ctl_soft`=1 while `seq_stat`=0 asserts `rst_host_if`, `rst_host_mac` and `rst_sysreg_lo` for exactly SOFT_CYC cycles, starting the cycle after the write; `phy_rst` is not asserted by it.
- R2: `tx_err_flag` and `rx_err_flag` are set by a one-cycle `tx_err_evt` or `rx_err_evt` and held. Both are cleared when a soft sequence starts, and events that arrive while the domain resets are asserted are ignored.
- R3: `straps_q` takes the value of `straps_in` on the first cycle after `rst_n` is released and keeps it through all later soft and PHY resets.
- R4: After the domain-reset interval, `ldr_req` rises with `ldr_mac_only`=1 and stays high until `ldr_done` is sampled. The pass started after power-on has `ldr_mac_only`=0.
- R5: `busy` is high from the first domain-reset cycle until the cycle in which `ldr_done` is sampled, which is SOFT_CYC plus the number of cycles `ldr_req` was high.
- R6: After `ldr_done`, `seq_stat` stays high for a settle interval of EXTRA_A_CYC cycles when `ldr_bus_sel`=0 and EXTRA_B_CYC cycles when `ldr_bus_sel`=1, with `busy` low; `seq_stat` then falls.
- R7: If `ldr_done` does not arrive within LDR_TMO_CYC cycles of `ldr_req`, `ldr_req` falls, `ldr_err` becomes 1, no settle interval follows, and `seq_stat` falls. `ldr_err` is cleared when the next sequence starts.
- R8: A soft write while `seq_stat`=1 is ignored: the sequence timing is unchanged.
- R9: A write with `ctl_phy[i]`=1 asserts `phy_rst[i]` for exactly PHY_CYC cycles, starting the cycle after the write. `phy_stat[i]` is high over the same cycles and then clears by itself. No other PHY is reset, and `ldr_req` is not raised.
- R10: A pulse on `pdn_exit[i]` gives the same reset on PHY i with `phy_keep_regs[i]`=1. If a host request for that PHY arrives together with it or is pending, `phy_keep_regs[i]` stays 0.
- R11: PHY requests made while `seq_stat`=1 are queued. `phy_stat[i]` is 1 and `phy_rst[i]` is 0 while the request waits. The reset starts in the cycle after `seq_stat` falls.
- R12: A request to a PHY whose reset is already running is ignored, and the pulse length stays PHY_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ctl_wr | input | 1 | One-cycle control register write strobe |
| ctl_soft | input | 1 | Soft sequence request bit of the write |
| ctl_phy | input | NPHY | Per-PHY reset request bits of the write |
| pdn_exit | input | NPHY | One-cycle pulse per PHY on leaving power-down |
| ldr_bus_sel | input | 1 | Loader memory bus type, selects settle length |
| straps_in | input | STRAP_W | Configuration strap pins |
| ldr_done | input | 1 | Loader completion pulse |
| tx_err_evt | input | 1 | Host MAC transmit error event |
| rx_err_evt | input | 1 | Host MAC receive error event |
| rst_host_if | output | 1 | Host bus interface reset |
| rst_host_mac | output | 1 | Host MAC reset |
| rst_sysreg_lo | output | 1 | Lower system register bank reset |
| busy | output | 1 | Domain reset or loader wait in progress |
| seq_stat | output | 1 | Sequence in progress, clears by itself |
| ldr_req | output | 1 | Loader start request, held until done |
| ldr_mac_only | output | 1 | Loader pass restricted to the MAC address |
| ldr_err | output | 1 | Sticky loader timeout flag |
| straps_q | output | STRAP_W | Straps captured after power-on |
| tx_err_flag | output | 1 | Latched transmit error |
| rx_err_flag | output | 1 | Latched receive error |
| phy_rst | output | NPHY | Per-PHY reset pulse |
| phy_keep_regs | output | NPHY | Reset must preserve PHY registers |
| phy_stat | output | NPHY | Per-PHY reset pending or running, clears by itself |

## Verification
A wrong sequencer state shows up within one cycle as a change in the lengths of the domain-reset, busy or settle windows. The bench measures these windows by counting cycles, for both bus types and several loader latencies. A stuck or mis-loaded counter in a PHY channel changes the measured pulse or status length. A broken hold path lets the pulse start while `seq_stat` is still high. A corrupted keep or merge flag is seen directly on `phy_keep_regs` during the pulse. Any unwanted recapture of the straps, or an error flag that is not cleared, stays visible on the outputs until the next reset, so a single check after each sequence catches it.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_RST    = 2'd1,
      SQ_LOAD   = 2'd2,
      SQ_SETTLE = 2'd3
   } sq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rst_seq_cnt.sv
module rst_seq_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (q != '0) begin
         q <= q - 1'b1;
      end
   end

   assign zero = (q == '0);

endmodule

// File: rtl/rst_seq_soft.sv
module rst_seq_soft
   import rst_seq_pkg::*;
#(
   parameter int SOFT_CYC    = 16,
   parameter int EXTRA_A_CYC = 8,
   parameter int EXTRA_B_CYC = 4,
   parameter int LDR_TMO_CYC = 32,
   parameter bit TMO_EN      = 1'b1,
   parameter int CW          = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_soft,
   input  logic bus_sel,
   input  logic ldr_done,
   output logic dom_rst,
   output logic busy,
   output logic active,
   output logic hold,
   output logic soft_go,
   output logic strap_cap,
   output logic ldr_req,
   output logic ldr_mac_only,
   output logic ldr_err
);

   sq_state_t     state_q, state_d;
   logic          por_q;
   logic          full_q;
   logic          err_q;
   logic          cnt_ld;
   logic [CW-1:0] cnt_val;
   logic          cnt_zero;
   logic          tmo_hit;
   logic [CW-1:0] extra_v;

   rst_seq_cnt #(.W(CW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (cnt_ld),
      .ld_val(cnt_val),
      .zero  (cnt_zero)
   );

   generate
      if (TMO_EN) begin : g_tmo
         assign tmo_hit = cnt_zero;
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   assign extra_v = bus_sel ? CW'(EXTRA_B_CYC - 1) : CW'(EXTRA_A_CYC - 1);
   assign soft_go = go_soft && (state_q == SQ_IDLE) && !por_q;

   always_comb begin
      state_d = state_q;
      cnt_ld  = 1'b0;
      cnt_val = '0;
      unique case (state_q)
         SQ_IDLE: begin
            if (por_q) begin
               state_d = SQ_LOAD;
               cnt_ld  = 1'b1;
               cnt_val = CW'(LDR_TMO_CYC - 1);
            end else if (soft_go) begin
               state_d = SQ_RST;
               cnt_ld  = 1'b1;
               cnt_val = CW'(SOFT_CYC - 1);
            end
         end
         SQ_RST: begin
            if (cnt_zero) begin
               state_d = SQ_LOAD;
               cnt_ld  = 1'b1;
               cnt_val = CW'(LDR_TMO_CYC - 1);
            end
         end
         SQ_LOAD: begin
            if (ldr_done) begin
               state_d = SQ_SETTLE;
               cnt_ld  = 1'b1;
               cnt_val = extra_v;
            end else if (tmo_hit) begin
               state_d = SQ_IDLE;
            end
         end
         SQ_SETTLE: begin
            if (cnt_zero) begin
               state_d = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         por_q   <= 1'b1;
         full_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         por_q   <= 1'b0;
         if (por_q) begin
            full_q <= 1'b1;
         end else if (soft_go) begin
            full_q <= 1'b0;
         end
         if ((state_q == SQ_IDLE) && (por_q || soft_go)) begin
            err_q <= 1'b0;
         end else if ((state_q == SQ_LOAD) && !ldr_done && tmo_hit) begin
            err_q <= 1'b1;
         end
      end
   end

   assign dom_rst      = (state_q == SQ_RST);
   assign busy         = (state_q == SQ_RST) || (state_q == SQ_LOAD);
   assign active       = (state_q != SQ_IDLE);
   assign hold         = active || por_q || soft_go;
   assign strap_cap    = por_q;
   assign ldr_req      = (state_q == SQ_LOAD);
   assign ldr_mac_only = (state_q == SQ_LOAD) && !full_q;
   assign ldr_err      = err_q;

endmodule

// File: rtl/rst_seq_phy.sv
module rst_seq_phy #(
   parameter int PHY_CYC = 8,
   parameter int PW      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic req_host,
   input  logic req_pdn,
   output logic rst_o,
   output logic keep_o,
   output logic stat_o
);

   logic          pend_q;
   logic          pend_keep_q;
   logic          act_q;
   logic          keep_q;
   logic          any_req;
   logic          keep_mrg;
   logic          start;
   logic          cnt_zero;

   assign any_req  = req_host || req_pdn;
   assign keep_mrg = (pend_q ? pend_keep_q : 1'b1) && !req_host;
   assign start    = !act_q && !hold && (pend_q || any_req);

   rst_seq_cnt #(.W(PW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (start),
      .ld_val(PW'(PHY_CYC - 1)),
      .zero  (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_keep_q <= 1'b0;
         act_q       <= 1'b0;
         keep_q      <= 1'b0;
      end else if (act_q) begin
         if (cnt_zero) begin
            act_q  <= 1'b0;
            keep_q <= 1'b0;
         end
      end else if (pend_q || any_req) begin
         if (hold) begin
            pend_q      <= 1'b1;
            pend_keep_q <= keep_mrg;
         end else begin
            act_q       <= 1'b1;
            keep_q      <= keep_mrg;
            pend_q      <= 1'b0;
            pend_keep_q <= 1'b0;
         end
      end
   end

   assign rst_o  = act_q;
   assign keep_o = act_q && keep_q;
   assign stat_o = act_q || pend_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
#(
   parameter int NPHY        = 2,
   parameter int STRAP_W     = 4,
   parameter int SOFT_CYC    = 14750,
   parameter int EXTRA_A_CYC = 13750,
   parameter int EXTRA_B_CYC = 4250,
   parameter int PHY_CYC     = 2750,
   parameter int LDR_TMO_CYC = 100000,
   parameter bit TMO_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic               ctl_soft,
   input  logic [NPHY-1:0]    ctl_phy,
   input  logic [NPHY-1:0]    pdn_exit,
   input  logic               ldr_bus_sel,
   input  logic [STRAP_W-1:0] straps_in,
   input  logic               ldr_done,
   input  logic               tx_err_evt,
   input  logic               rx_err_evt,
   output logic               rst_host_if,
   output logic               rst_host_mac,
   output logic               rst_sysreg_lo,
   output logic               busy,
   output logic               seq_stat,
   output logic               ldr_req,
   output logic               ldr_mac_only,
   output logic               ldr_err,
   output logic [STRAP_W-1:0] straps_q,
   output logic               tx_err_flag,
   output logic               rx_err_flag,
   output logic [NPHY-1:0]    phy_rst,
   output logic [NPHY-1:0]    phy_keep_regs,
   output logic [NPHY-1:0]    phy_stat
);

   localparam int SEQ_MAX = imax(imax(SOFT_CYC, LDR_TMO_CYC), imax(EXTRA_A_CYC, EXTRA_B_CYC));
   localparam int CW      = $clog2(SEQ_MAX + 1);
   localparam int PW      = $clog2(PHY_CYC + 1);

   generate
      if (NPHY < 1) begin : g_bad_nphy
         $error("rst_seq_ctrl: NPHY must be at least 1");
      end
      if (STRAP_W < 1) begin : g_bad_strap
         $error("rst_seq_ctrl: STRAP_W must be at least 1");
      end
      if ((SOFT_CYC < 1) || (PHY_CYC < 1) || (LDR_TMO_CYC < 1)) begin : g_bad_cyc
         $error("rst_seq_ctrl: reset and timeout intervals must be at least one cycle");
      end
      if ((EXTRA_A_CYC < 1) || (EXTRA_B_CYC < 1)) begin : g_bad_extra
         $error("rst_seq_ctrl: settle intervals must be at least one cycle");
      end
   endgenerate

   logic dom_rst;
   logic seq_hold;
   logic soft_go;
   logic strap_cap;
   logic err_clr;

   rst_seq_soft #(
      .SOFT_CYC   (SOFT_CYC),
      .EXTRA_A_CYC(EXTRA_A_CYC),
      .EXTRA_B_CYC(EXTRA_B_CYC),
      .LDR_TMO_CYC(LDR_TMO_CYC),
      .TMO_EN     (TMO_EN),
      .CW         (CW)
   ) i_soft (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_soft     (ctl_wr && ctl_soft),
      .bus_sel     (ldr_bus_sel),
      .ldr_done    (ldr_done),
      .dom_rst     (dom_rst),
      .busy        (busy),
      .active      (seq_stat),
      .hold        (seq_hold),
      .soft_go     (soft_go),
      .strap_cap   (strap_cap),
      .ldr_req     (ldr_req),
      .ldr_mac_only(ldr_mac_only),
      .ldr_err     (ldr_err)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NPHY; gi++) begin : g_phy
         rst_seq_phy #(
            .PHY_CYC(PHY_CYC),
            .PW     (PW)
         ) i_phy (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (seq_hold),
            .req_host(ctl_wr && ctl_phy[gi]),
            .req_pdn (pdn_exit[gi]),
            .rst_o   (phy_rst[gi]),
            .keep_o  (phy_keep_regs[gi]),
            .stat_o  (phy_stat[gi])
         );
      end
   endgenerate

   assign err_clr = soft_go || dom_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         straps_q    <= '0;
         tx_err_flag <= 1'b0;
         rx_err_flag <= 1'b0;
      end else begin
         if (strap_cap) begin
            straps_q <= straps_in;
         end
         if (err_clr) begin
            tx_err_flag <= 1'b0;
            rx_err_flag <= 1'b0;
         end else begin
            if (tx_err_evt) tx_err_flag <= 1'b1;
            if (rx_err_evt) rx_err_flag <= 1'b1;
         end
      end
   end

   assign rst_host_if   = dom_rst;
   assign rst_host_mac  = dom_rst;
   assign rst_sysreg_lo = dom_rst;

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
   parameter int NPHY    = 2,
   parameter int STRAP_W = 4,
   parameter int PHY_CYC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               seq_stat,
   input logic               ldr_req,
   input logic               ldr_mac_only,
   input logic               ldr_done,
   input logic               rst_host_if,
   input logic               tx_err_flag,
   input logic               rx_err_flag,
   input logic [STRAP_W-1:0] straps_q,
   input logic [NPHY-1:0]    phy_rst,
   input logic [NPHY-1:0]    phy_keep_regs,
   input logic [NPHY-1:0]    phy_stat
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   AST_DOM_RST_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rst_host_if |-> busy); // R5
   AST_ERR_HELD_CLR: assert property (@(posedge clk) disable iff (!rst_n) rst_host_if |-> (!tx_err_flag && !rx_err_flag)); // R2
   AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n) armed_q |=> $stable(straps_q)); // R3
   AST_MODE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) ldr_mac_only |-> ldr_req); // R4
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ldr_req && ldr_done) |=> !ldr_req); // R4
   AST_BUSY_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) busy |-> seq_stat); // R6

   genvar gi;
   generate
      for (gi = 0; gi < NPHY; gi++) begin : g_phy_chk
         int run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           run_q <= 0;
            else if (phy_rst[gi]) run_q <= run_q + 1;
            else                  run_q <= 0;
         end
         AST_PHY_LEN: assert property (@(posedge clk) disable iff (!rst_n) phy_rst[gi] |-> (run_q < PHY_CYC)); // R12
         AST_PHY_STAT: assert property (@(posedge clk) disable iff (!rst_n) phy_rst[gi] |-> phy_stat[gi]); // R9
         AST_PHY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) phy_keep_regs[gi] |-> phy_rst[gi]); // R10
         AST_PHY_QUEUED: assert property (@(posedge clk) disable iff (!rst_n) $rose(phy_rst[gi]) |-> !seq_stat); // R11
      end
   endgenerate

endmodule

bind rst_seq_ctrl rst_seq_chk #(
   .NPHY   (NPHY),
   .STRAP_W(STRAP_W),
   .PHY_CYC(PHY_CYC)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .seq_stat     (seq_stat),
   .ldr_req      (ldr_req),
   .ldr_mac_only (ldr_mac_only),
   .ldr_done     (ldr_done),
   .rst_host_if  (rst_host_if),
   .tx_err_flag  (tx_err_flag),
   .rx_err_flag  (rx_err_flag),
   .straps_q     (straps_q),
   .phy_rst      (phy_rst),
   .phy_keep_regs(phy_keep_regs),
   .phy_stat     (phy_stat)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NPHY  = 2;
   localparam int SW    = 4;
   localparam int SOFT  = 5;
   localparam int EXA   = 4;
   localparam int EXB   = 2;
   localparam int PHYC  = 3;
   localparam int TMO   = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctl_wr = 1'b0;
   logic            ctl_soft = 1'b0;
   logic [NPHY-1:0] ctl_phy = '0;
   logic [NPHY-1:0] pdn_exit = '0;
   logic            ldr_bus_sel = 1'b0;
   logic [SW-1:0]   straps_in = 4'hA;
   logic            ldr_done = 1'b0;
   logic            tx_err_evt = 1'b0;
   logic            rx_err_evt = 1'b0;
   logic            rst_host_if, rst_host_mac, rst_sysreg_lo;
   logic            busy, seq_stat, ldr_req, ldr_mac_only, ldr_err;
   logic [SW-1:0]   straps_q;
   logic            tx_err_flag, rx_err_flag;
   logic [NPHY-1:0] phy_rst, phy_keep_regs, phy_stat;

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_seq_ctrl #(
      .NPHY(NPHY), .STRAP_W(SW), .SOFT_CYC(SOFT), .EXTRA_A_CYC(EXA),
      .EXTRA_B_CYC(EXB), .PHY_CYC(PHYC), .LDR_TMO_CYC(TMO), .TMO_EN(1'b1)
   ) i_rst_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_soft(ctl_soft),
      .ctl_phy(ctl_phy), .pdn_exit(pdn_exit), .ldr_bus_sel(ldr_bus_sel),
      .straps_in(straps_in), .ldr_done(ldr_done), .tx_err_evt(tx_err_evt),
      .rx_err_evt(rx_err_evt), .rst_host_if(rst_host_if), .rst_host_mac(rst_host_mac),
      .rst_sysreg_lo(rst_sysreg_lo), .busy(busy), .seq_stat(seq_stat),
      .ldr_req(ldr_req), .ldr_mac_only(ldr_mac_only), .ldr_err(ldr_err),
      .straps_q(straps_q), .tx_err_flag(tx_err_flag), .rx_err_flag(rx_err_flag),
      .phy_rst(phy_rst), .phy_keep_regs(phy_keep_regs), .phy_stat(phy_stat)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic soft_run(input bit bus, input int d, input bit tmo, input bit midwr);
      int n_rst = 0, n_busy = 0, n_load = 0, n_set = 0, n_stat = 0;
      int bad_mode = 0, phy_seen = 0, dom_mis = 0, err0 = -1;
      int exp_load;
      @(negedge clk);
      ctl_wr = 1'b1; ctl_soft = 1'b1; ldr_bus_sel = bus;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_soft = 1'b0;
      for (int k = 0; k < 200; k++) begin
         ldr_done = 1'b0; ctl_wr = 1'b0; ctl_soft = 1'b0; rx_err_evt = 1'b0;
         if (!seq_stat) break;
         if (k == 0) err0 = ldr_err;
         if (rst_host_if) n_rst++;
         if ((rst_host_if != rst_host_mac) || (rst_host_if != rst_sysreg_lo)) dom_mis++;
         if (busy) n_busy++;
         if (!busy) n_set++;
         if (phy_rst != '0) phy_seen++;
         if (ldr_req) begin
            n_load++;
            if (!ldr_mac_only) bad_mode++;
            if (!tmo && n_load == d) ldr_done = 1'b1;
         end
         if (k == 1) rx_err_evt = 1'b1;
         if (midwr && k == 2) begin ctl_wr = 1'b1; ctl_soft = 1'b1; end
         n_stat++;
         @(negedge clk);
      end
      exp_load = tmo ? TMO : d;
      chk("R1 domain reset cycles", n_rst, SOFT);
      chk("R1 domain resets equal", dom_mis, 0);
      chk("R1 no phy reset", phy_seen, 0);
      chk("R4 restricted loader mode", bad_mode, 0);
      chk("R4 loader request cycles", n_load, exp_load);
      chk("R5 busy cycles", n_busy, SOFT + exp_load);
      chk("R6 settle cycles", n_set, tmo ? 0 : (bus ? EXB : EXA));
      chk("R6 sequence status cycles", n_stat, SOFT + exp_load + (tmo ? 0 : (bus ? EXB : EXA)));
      chk("R7 error flag after", ldr_err, tmo);
      chk("R7 error cleared at start", err0, 0);
      chk("R2 rx flag ignored in reset", rx_err_flag, 0);
      chk("R2 tx flag cleared", tx_err_flag, 0);
      chk("R3 straps kept", straps_q, 4'hA);
      if (midwr) chk("R8 soft write ignored", n_stat, SOFT + d + (bus ? EXB : EXA));
   endtask

   task automatic phy_run(input logic [1:0] h, input logic [1:0] p, input bit retrig);
      int nr[2], nk[2], ns[2];
      int req_seen = 0;
      for (int i = 0; i < 2; i++) begin nr[i] = 0; nk[i] = 0; ns[i] = 0; end
      @(negedge clk);
      ctl_wr = (h != 2'b00); ctl_phy = h; pdn_exit = p;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_phy = '0; pdn_exit = '0;
      for (int k = 0; k < 50; k++) begin
         ctl_wr = 1'b0; ctl_phy = '0; pdn_exit = '0;
         if (phy_stat == '0) break;
         for (int i = 0; i < 2; i++) begin
            if (phy_rst[i]) nr[i]++;
            if (phy_keep_regs[i]) nk[i]++;
            if (phy_stat[i]) ns[i]++;
         end
         if (ldr_req) req_seen++;
         if (retrig && k == 1) begin ctl_wr = (h != 2'b00); ctl_phy = h; pdn_exit = p; end
         @(negedge clk);
      end
      for (int i = 0; i < 2; i++) begin
         chk(retrig ? "R12 retrigger pulse length" : "R9 phy pulse length", nr[i], (h[i] | p[i]) ? PHYC : 0);
         chk("R9 phy status length", ns[i], (h[i] | p[i]) ? PHYC : 0);
         chk("R10 keep-registers cycles", nk[i], (p[i] & ~h[i]) ? PHYC : 0);
      end
      chk("R9 no loader request", req_seen, 0);
      chk("R3 straps kept after phy", straps_q, 4'hA);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R4 reset ldr_req", ldr_req, 0);
      chk("R5 reset busy", busy, 0);
      chk("R3 reset straps", straps_q, 0);
      chk("R9 reset phy_stat", phy_stat, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 straps captured", straps_q, 4'hA);
      chk("R4 power-on loader request", ldr_req, 1);
      chk("R4 power-on full pass", ldr_mac_only, 0);
      ldr_done = 1'b1;
      @(negedge clk);
      ldr_done = 1'b0;
      for (int k = 0; k < 50 && seq_stat; k++) @(negedge clk);
      chk("R6 power-on sequence ends", seq_stat, 0);
      straps_in = 4'h5;

      tx_err_evt = 1'b1;
      @(negedge clk);
      tx_err_evt = 1'b0;
      chk("R2 tx flag set", tx_err_flag, 1);

      for (int b = 0; b < 2; b++)
         for (int d = 1; d <= 3; d++)
            soft_run(b[0], d, 1'b0, 1'b0);
      soft_run(1'b0, 1, 1'b1, 1'b0);
      soft_run(1'b1, 2, 1'b0, 1'b0);
      soft_run(1'b0, 2, 1'b0, 1'b1);

      tx_err_evt = 1'b1;
      @(negedge clk);
      tx_err_evt = 1'b0;
      chk("R2 tx flag set again", tx_err_flag, 1);
      soft_run(1'b1, 1, 1'b0, 1'b0);

      for (int h = 0; h < 4; h++)
         for (int p = 0; p < 4; p++)
            if (h != 0 || p != 0) phy_run(h[1:0], p[1:0], 1'b0);
      phy_run(2'b01, 2'b00, 1'b1);
      phy_run(2'b00, 2'b10, 1'b1);

      // R11: requests during a sequence are queued
      @(negedge clk);
      ctl_wr = 1'b1; ctl_soft = 1'b1;
      @(negedge clk);
      ctl_soft = 1'b0; ctl_phy = 2'b01; pdn_exit = 2'b10;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_phy = '0; pdn_exit = '0;
      chk("R11 pending status", phy_stat, 3);
      chk("R11 no early reset", phy_rst, 0);
      n = 0;
      for (int k = 0; k < 100; k++) begin
         ldr_done = 1'b0;
         if (!seq_stat) break;
         if (phy_rst != '0) n++;
         if (ldr_req) ldr_done = 1'b1;
         @(negedge clk);
      end
      ldr_done = 1'b0;
      chk("R11 held during sequence", n, 0);
      chk("R11 still pending at end", phy_stat, 3);
      chk("R11 not started yet", phy_rst, 0);
      @(negedge clk);
      chk("R11 started after sequence", phy_rst, 3);
      chk("R10 queued keep flags", phy_keep_regs, 2);
      n = 1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (phy_rst == 2'b11) n++;
      end
      chk("R11 queued pulse length", n, PHYC);
      chk("R9 status cleared", phy_stat, 0);

      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done_flag) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule